// File: doc/BRIEF.md
# Binary Phase-Shift Carrier Generator

This block produces a stream of signed sine samples for a digital-to-analog converter and keys the carrier phase with a single data line. A free-running phase accumulator, advanced every clock by a tuning word, picks entries from a full-cycle sine table. That table is computed at elaboration and read through a registered port, so it maps onto on-chip block memory. The table sample then passes through a stage that either forwards it unchanged or negates it in two's complement. Negating the sample shifts the carrier by half a cycle.

The data line is asynchronous to the block. It is brought in through two flip-flops. Every change of its level, rising or falling, toggles an internal invert state, and that state drives the negation stage. The output frequency is tune × f_clk / 2^32. With a 50 MHz clock, a 1 MHz carrier uses a tuning word of 85899346.

Top module: `bpsk_carrier_mod`

## Requirements
- R1: While `rst_n` is low at a clock edge, `valid_o` is 0 and `sample_o` is 0 after that edge. The accumulator and the invert state are cleared, so the first samples after reset are never negated unless data changes.
- R2: The 32-bit accumulator starts at 0 and adds `tune_i` on every clock edge, wrapping modulo 2^32. Bits [31:22] of the accumulator give the table index.
- R3: Table entry i (0 to 1023) is 32767·sin(2π·i/1024) rounded to the nearest integer, with halves rounded away from zero.
- R4: The first clock edge after reset release leaves `valid_o` at 0. From the second edge on, `valid_o` is 1 on every edge. The output after edge m (m ≥ 2) is the table entry at accumulator value (m−2)·tune.
- R5: A level change on `data_i` that is first captured by edge N toggles the invert state. Every output from edge N+4 onward carries the new sign. This holds for changes in either direction.
- R6: When inverted, the output is the exact two's-complement negation of the table entry. The output never equals −32768.
- R7: A data pulse one clock long gives two toggles on consecutive edges, so exactly one output sample is negated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| data_i | input | 1 | Asynchronous keying data line |
| tune_i | input | 32 | Phase increment per clock |
| sample_o | output | 16 | Signed carrier sample, two's complement |
| valid_o | output | 1 | High while `sample_o` holds a carrier sample |

## Verification
A sign change arriving from the data path can land in the same cycle that the accumulator wraps past zero. It can also land on the cycle that reads a table peak. The bench keys data at a fixed stride that is prime with respect to the table period. It runs a backward-stepping tuning word so that wraps happen often, and it sends a single-cycle pulse so that two toggles fall on adjacent cycles. Each sample is judged against a model in the bench. That model takes the table index from (m−2)·tune and the sign from the parity of the data changes whose effect edge has been reached.

// File: rtl/bpsk_pkg.sv
// Shared constants and the sine code function used to build the carrier table.
// Assumes amplitude fits in the sample width with one code of headroom.
package bpsk_pkg;

    localparam real TWO_PI = 6.283185307179586;

    // Rounded sine code for table slot idx of a depth-entry full cycle.
    function automatic int sine_code(input int idx, input int depth, input int amp);
        real x;
        x = real'(amp) * $sin(TWO_PI * real'(idx) / real'(depth));
        if (x >= 0.0) return $rtoi(x + 0.5);
        else          return -$rtoi(-x + 0.5);
    endfunction

endpackage

// File: rtl/phase_accum.sv
// Phase accumulator: adds the tuning word each clock, exposes the top bits
// as a table index. Assumes ADDR_W <= PHASE_W.
module phase_accum #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tune_i,
    output logic [ADDR_W-1:0]  index_o
);
    logic [PHASE_W-1:0] acc_q;

    // Advance phase by the tuning word, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_q + tune_i;
    end

    assign index_o = acc_q[PHASE_W-1 -: ADDR_W];

    // R2: phase moves by exactly the previous tuning word each running cycle
    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> acc_q == $past(acc_q) + $past(tune_i));

endmodule

// File: rtl/sine_rom.sv
// Full-cycle sine table with a registered read port (block memory style).
// Contents are computed at elaboration; amplitude is 2^(W-1)-1, so the most
// negative code is never stored.
module sine_rom
    import bpsk_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int SAMP_W = 16
) (
    input  logic                     clk,
    input  logic [ADDR_W-1:0]        addr_i,
    output logic signed [SAMP_W-1:0] data_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int AMP   = (1 << (SAMP_W - 1)) - 1;

    logic signed [SAMP_W-1:0] table_w [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_fill
        localparam int CODE = sine_code(i, DEPTH, AMP);
        assign table_w[i] = SAMP_W'(CODE);
    end

    // Registered table read.
    always_ff @(posedge clk) begin
        data_o <= table_w[addr_i];
    end

    // R6: the stored code can never be the unnegatable minimum
    a_r6_table_floor: assert property (@(posedge clk)
        data_o != {1'b1, {(SAMP_W-1){1'b0}}});

endmodule

// File: rtl/flip_tracker.sv
// Brings the data line in through two flops, and toggles the invert state on
// every level change seen after synchronisation. Assumes data_i is asynchronous.
module flip_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic data_i,
    output logic inv_o
);
    logic sync1_q, sync2_q, prev_q;

    // Two-stage synchroniser plus one history flop for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= data_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    // Toggle invert on each detected level change.
    always_ff @(posedge clk) begin
        if (!rst_n) inv_o <= 1'b0;
        else        inv_o <= inv_o ^ (sync2_q ^ prev_q);
    end

    // R5: without a detected change the invert state holds
    a_r5_hold_without_change: assert property (@(posedge clk) disable iff (!rst_n)
        (sync2_q == prev_q) |=> $stable(inv_o));

endmodule

// File: rtl/neg_stage.sv
// Output stage: forwards or two's-complement negates the table sample and
// registers it along with its valid flag. Assumes the input is never the
// minimum code.
module neg_stage #(
    parameter int SAMP_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     inv_i,
    input  logic                     valid_i,
    input  logic signed [SAMP_W-1:0] samp_i,
    output logic signed [SAMP_W-1:0] samp_o,
    output logic                     valid_o
);
    // Register the bypassed or negated sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            samp_o  <= inv_i ? -samp_i : samp_i;
            valid_o <= valid_i;
        end
    end

endmodule

// File: rtl/bpsk_carrier_mod.sv
// Top level: accumulator -> registered sine table -> negation stage, with the
// invert state delayed one cycle to line up with the table read.
// Latency from accumulator value to output is two clocks.
module bpsk_carrier_mod #(
    parameter int PHASE_W = 32,
    parameter int ADDR_W  = 10,
    parameter int SAMP_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     data_i,
    input  logic [PHASE_W-1:0]       tune_i,
    output logic signed [SAMP_W-1:0] sample_o,
    output logic                     valid_o
);
    logic [ADDR_W-1:0]        index_w;
    logic signed [SAMP_W-1:0] rom_q;
    logic                     inv_w;
    logic                     inv_d;
    logic                     fill_q;

    phase_accum #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .tune_i(tune_i), .index_o(index_w)
    );

    sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_rom (
        .clk(clk), .addr_i(index_w), .data_o(rom_q)
    );

    flip_tracker u_flip (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .inv_o(inv_w)
    );

    // Align invert state with the table read and mark the first pipeline fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_d  <= 1'b0;
            fill_q <= 1'b0;
        end else begin
            inv_d  <= inv_w;
            fill_q <= 1'b1;
        end
    end

    neg_stage #(.SAMP_W(SAMP_W)) u_neg (
        .clk(clk), .rst_n(rst_n), .inv_i(inv_d), .valid_i(fill_q),
        .samp_i(rom_q), .samp_o(sample_o), .valid_o(valid_o)
    );

    // R4: once valid, it stays valid until reset
    a_r4_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

    // R6: the output never reaches the minimum code
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> sample_o != {1'b1, {(SAMP_W-1){1'b0}}});

endmodule

// File: tb/sim_bpsk_carrier_mod.sv
`timescale 1ns/1ps
module sim_bpsk_carrier_mod;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               data_i = 1'b0;
    logic [31:0]        tune_i = '0;
    logic signed [15:0] sample_o;
    logic               valid_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int m;               // edges since reset release
    int chg_edge [64];   // edge that first captures each data change
    int n_chg;

    always #2 clk = ~clk;

    bpsk_carrier_mod u0 (
        .clk(clk), .rst_n(rst_n), .data_i(data_i), .tune_i(tune_i),
        .sample_o(sample_o), .valid_o(valid_o)
    );

    // Table entry from R3, computed arithmetically.
    function automatic int ref_tab(input int i);
        real x;
        x = 32767.0 * $sin(6.283185307179586 * real'(i) / 1024.0);
        if (x >= 0.0) return $rtoi(x + 0.5);
        else          return -$rtoi(-x + 0.5);
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s edge=%0d got %0d expected %0d", req, m, got, exp);
        end
    endtask

    // Expected output after edge m (R4, R5, R6, R7).
    function automatic int expect_at(input int edge_m, input logic [31:0] tw);
        longint ph;
        int idx, val, flips;
        ph  = (longint'(edge_m - 2) * longint'(tw)) & 64'hFFFF_FFFF;
        idx = int'(ph >> 22);
        val = ref_tab(idx);
        flips = 0;
        for (int e = 0; e < n_chg; e++)
            if (chg_edge[e] + 4 <= edge_m) flips++;
        return (flips % 2 == 1) ? -val : val;
    endfunction

    // mode 0: none, 1: stride flips, 2: one-cycle pulse
    task automatic run_case(input logic [31:0] tw, input int cycles, input int mode);
        @(negedge clk);
        rst_n = 1'b0;
        data_i = 1'b0;
        tune_i = tw;
        n_chg = 0;
        for (int r = 0; r < 3; r++) begin
            @(negedge clk);
            check("R1 valid in reset", int'(valid_o), 0);
            check("R1 sample in reset", int'(sample_o), 0);
        end
        rst_n = 1'b1;
        m = 0;
        for (int c = 0; c < cycles; c++) begin
            @(posedge clk);
            m++;
            @(negedge clk);
            if (m == 1) check("R4 first edge not valid", int'(valid_o), 0);
            else begin
                check("R4 valid", int'(valid_o), 1);
                check((mode == 2) ? "R7 pulse sample" :
                      (mode == 1) ? "R5/R6 keyed sample" : "R2/R3 sample",
                      int'(sample_o), expect_at(m, tw));
                if (int'(sample_o) == -32768) check("R6 overflow", int'(sample_o), 0);
            end
            if ((mode == 1 && (m % 37) == 10 && n_chg < 64) ||
                (mode == 2 && (m == 50 || m == 51))) begin
                data_i = ~data_i;
                chg_edge[n_chg] = m + 1;
                n_chg++;
            end
        end
    endtask

    initial begin
        run_case(32'h0040_0000, 1030, 0);   // every table entry once (R2, R3)
        run_case(32'd85899346, 400, 1);     // 1 MHz at 50 MHz, keyed both directions
        run_case(32'hFFC0_0000, 300, 2);    // backward step, wraps, single pulse (R7)
        run_case(32'h1234_5678, 600, 1);    // odd step with keying
        run_case(32'h0040_0000, 40, 0);     // after keyed run: invert cleared (R1)
        run_case(32'h0000_0000, 60, 1);     // zero step, keyed zero sample
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule